// File: doc/BRIEF.md
# Serial-In Serial-Out Sequential Adder

This block adds two small two's complement operands under a built-in controller. A start strobe begins a calculation. Operand A then arrives one bit per clock on a serial input and is collected into a parallel word. Operand B is taken from a parallel bus in a single latch cycle. The sum is stored in an output register, and that register is then shifted out one bit per clock. The serial output is always the register's least significant bit.

A done flag marks the end of each calculation for one cycle. The controller holds a state register that steps on every clock edge. A combinational decoder turns the state into the phase strobes, and a step counter measures the multi-cycle phases. An asynchronous reset drops any calculation in progress.

Top module: `seqadd_serial`

## Requirements
- R1: While `rst` is high, `c_ser` and `done` are 0, and they are 0 in the first cycle after `rst` falls.
- R2: The clock edge that sees `start` high in the idle state opens the collect phase. The next 4 rising edges sample `a_ser` as bits 0, 1, 2 and 3 of operand A, in that order (LSB first).
- R3: `b_in` is sampled only on the single edge that follows the collect phase. Its value at any other time has no effect on the result.
- R4: The stored result is (A + B) mod 16. The carry-out is dropped, so the addition wraps as two's complement.
- R5: On the edge after the B latch edge, the result is loaded and `c_ser` shows its bit 0. On each of the next 4 edges the register shifts right with a zero fill, so `c_ser` shows bits 1, 2 and 3 in turn, and then 0.
- R6: `done` is high for exactly one cycle, right after the fourth shift edge, and is low again in the next cycle.
- R7: A `start` pulse seen while a calculation is in progress is ignored. It neither restarts nor stretches the sequence.
- R8: In the idle state without `start`, activity on `a_ser` and `b_in` leaves `c_ser` and `done` unchanged.
- R9: Raising `rst` in the middle of a calculation drops it at once, and a calculation started after reset gives the correct result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| start | input | 1 | Begins a calculation when the block is idle |
| a_ser | input | 1 | Serial operand A, LSB first |
| b_in | input | 4 | Parallel operand B |
| c_ser | output | 1 | Serial result, bit 0 of the output register |
| done | output | 1 | One-cycle end-of-calculation flag |

## Verification
If the controller is in the wrong state or its step counter is off by one, `c_ser` shows a misordered or shifted bit pattern. `done` also fires a cycle early or late, and both errors appear within the same calculation, no more than eleven cycles after `start`. A wrong bit in operand A or B, or a lost carry bit inside the sum, shows up in the serial word as soon as the shifted-out bit is reached. A register that is not cleared on reset shows up on `c_ser` in the very cycle that reset is raised.

// File: rtl/seqadd_pkg.sv
package seqadd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_COLLECT = 3'd1,
        ST_LATCH   = 3'd2,
        ST_SUM     = 3'd3,
        ST_SHIFT   = 3'd4,
        ST_DONE    = 3'd5
    } seq_state_t;

    typedef struct packed {
        logic collect;
        logic latch_b;
        logic load_c;
        logic shift_c;
        logic fin;
    } seq_strobe_t;

    localparam seq_strobe_t STROBE_NONE = '{default: 1'b0};

    function automatic logic [31:0] wrap_add(input logic [31:0] x,
                                             input logic [31:0] y,
                                             input int unsigned w);
        logic [31:0] mask;
        mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        return (x + y) & mask;
    endfunction

endpackage

// File: rtl/seqadd_ctrl.sv
module seqadd_ctrl
    import seqadd_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    output seq_strobe_t strobe
);
    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    seq_state_t state_q, state_d;
    logic [CW-1:0] step_q, step_d;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        strobe  = STROBE_NONE;
        unique case (state_q)
            ST_IDLE: begin
                step_d = '0;
                if (start) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                strobe.collect = 1'b1;
                if (step_q == LAST) begin
                    step_d  = '0;
                    state_d = ST_LATCH;
                end else begin
                    step_d = step_q + 1'b1;
                end
            end
            ST_LATCH: begin
                strobe.latch_b = 1'b1;
                state_d        = ST_SUM;
            end
            ST_SUM: begin
                strobe.load_c = 1'b1;
                state_d       = ST_SHIFT;
            end
            ST_SHIFT: begin
                strobe.shift_c = 1'b1;
                if (step_q == LAST) begin
                    step_d  = '0;
                    state_d = ST_DONE;
                end else begin
                    step_d = step_q + 1'b1;
                end
            end
            ST_DONE: begin
                strobe.fin = 1'b1;
                state_d    = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
                step_d  = '0;
            end
        endcase
    end

    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({strobe.collect, strobe.latch_b, strobe.load_c, strobe.shift_c, strobe.fin})); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        strobe.fin |=> !strobe.fin); // R6
    AST_LATCH_AFTER_COLLECT: assert property (@(posedge clk) disable iff (rst)
        strobe.latch_b |=> strobe.load_c); // R3
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
        (strobe.collect && step_q != LAST) |=> strobe.collect); // R7

endmodule

// File: rtl/seqadd_sipo.sv
module seqadd_sipo #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             din,
    output logic [WIDTH-1:0] word
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst)     word <= '0;
        else if (en) word <= {din, word[WIDTH-1:1]};
    end

    AST_SIPO_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(word)); // R2
    AST_SIPO_MSB_ENTRY: assert property (@(posedge clk) disable iff (rst)
        en |=> word[WIDTH-1] == $past(din)); // R2

endmodule

// File: rtl/seqadd_breg.sv
module seqadd_breg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

    AST_B_ONLY_ON_LATCH: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q)); // R3

endmodule

// File: rtl/seqadd_piso.sv
module seqadd_piso #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             shift,
    input  logic [WIDTH-1:0] d,
    output logic             sout
);
    logic [WIDTH-1:0] q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)        q <= '0;
        else if (load)  q <= d;
        else if (shift) q <= {1'b0, q[WIDTH-1:1]};
    end

    assign sout = q[0];

    AST_LOAD_SUM: assert property (@(posedge clk) disable iff (rst)
        load |=> q == $past(d)); // R4
    AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |=> q == ($past(q) >> 1)); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!shift && !load) |=> $stable(sout)); // R8

endmodule

// File: rtl/seqadd_serial.sv
module seqadd_serial
    import seqadd_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             a_ser,
    input  logic [WIDTH-1:0] b_in,
    output logic             c_ser,
    output logic             done
);
    seq_strobe_t      strobe;
    logic [WIDTH-1:0] a_word;
    logic [WIDTH-1:0] b_word;
    logic [WIDTH-1:0] sum_word;

    seqadd_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .strobe (strobe)
    );

    seqadd_sipo #(.WIDTH(WIDTH)) u_sipo (
        .clk  (clk),
        .rst  (rst),
        .en   (strobe.collect),
        .din  (a_ser),
        .word (a_word)
    );

    seqadd_breg #(.WIDTH(WIDTH)) u_breg (
        .clk  (clk),
        .rst  (rst),
        .load (strobe.latch_b),
        .d    (b_in),
        .q    (b_word)
    );

    assign sum_word = WIDTH'(wrap_add(32'(a_word), 32'(b_word), WIDTH));

    seqadd_piso #(.WIDTH(WIDTH)) u_piso (
        .clk   (clk),
        .rst   (rst),
        .load  (strobe.load_c),
        .shift (strobe.shift_c),
        .d     (sum_word),
        .sout  (c_ser)
    );

    assign done = strobe.fin;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |-> (!done && !c_ser)); // R1

endmodule

// File: tb/seqadd_serial_tb.sv
`timescale 1ns/1ps
module seqadd_serial_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic       a_ser;
    logic [3:0] b_in;
    logic       c_ser;
    logic       done;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    seqadd_serial #(.WIDTH(4)) u_dut (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .a_ser (a_ser),
        .b_in  (b_in),
        .c_ser (c_ser),
        .done  (done)
    );

    function automatic logic [3:0] exp_sum(input logic [3:0] a, input logic [3:0] b);
        logic [4:0] full;
        full = {1'b0, a} + {1'b0, b};
        return full[3:0];
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // runs one calculation; busy_start pulses start during collect (R7)
    task automatic run_op(input logic [3:0] a, input logic [3:0] b, input bit busy_start);
        logic [3:0] s;
        s = exp_sum(a, b);
        @(negedge clk);
        start = 1'b1;
        b_in  = 4'($urandom);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            a_ser = a[i];
            b_in  = 4'($urandom);
            if (busy_start && i == 1) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
            chk("R6 done low while collecting", done, 1'b0);
        end
        start = 1'b0;
        a_ser = 1'($urandom);
        b_in  = b;
        @(negedge clk);
        b_in  = ~b;
        @(negedge clk);
        chk("R4 R5 bit0 after load", c_ser, s[0]);
        chk("R6 done low at load", done, 1'b0);
        for (int i = 1; i < 4; i++) begin
            b_in = 4'($urandom);
            if (busy_start) start = 1'b1;
            @(negedge clk);
            chk("R5 shifted bit", c_ser, s[i]);
            chk("R3 R4 R7 no early done", done, 1'b0);
        end
        start = 1'b0;
        @(negedge clk);
        chk("R6 done after last shift", done, 1'b1);
        chk("R5 zero fill after shifts", c_ser, 1'b0);
        @(negedge clk);
        chk("R6 done one cycle", done, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst   = 1'b1;
        start = 1'b0;
        a_ser = 1'b0;
        b_in  = 4'h0;
        #1;
        chk("R1 c_ser in reset", c_ser, 1'b0);
        chk("R1 done in reset", done, 1'b0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 c_ser after reset", c_ser, 1'b0);
        chk("R1 done after reset", done, 1'b0);

        // directed corners
        run_op(4'h0, 4'h0, 1'b0);
        run_op(4'hF, 4'h1, 1'b0);  // R4 wrap to 0
        run_op(4'h7, 4'h1, 1'b0);  // R4 signed overflow
        run_op(4'h8, 4'h8, 1'b0);  // R4 carry dropped
        run_op(4'h5, 4'hA, 1'b0);  // R2 alternating pattern
        run_op(4'h1, 4'h2, 1'b1);  // R7 start while busy

        // R8 idle ignores serial and parallel activity
        for (int i = 0; i < 6; i++) begin
            a_ser = 1'($urandom);
            b_in  = 4'($urandom);
            @(negedge clk);
            chk("R8 idle c_ser held", c_ser, 1'b0);
            chk("R8 idle done low", done, 1'b0);
        end

        // R9 reset mid calculation
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        a_ser = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b1;
        #1;
        chk("R9 c_ser on mid reset", c_ser, 1'b0);
        chk("R9 done on mid reset", done, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        repeat (6) begin
            @(negedge clk);
            chk("R9 stays idle after reset", done, 1'b0);
        end
        run_op(4'hB, 4'h6, 1'b0);

        // random mix
        for (int k = 0; k < 60; k++) begin
            run_op(4'($urandom), 4'($urandom), 1'($urandom));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule